// File: doc/BRIEF.md
# Prescaled I2C SCL Timing Generator

This block sets the shape of the serial clock for an I2C master. A 32-bit configuration word on `cfg_i` holds three fields. A 4-bit exponent E divides the system clock by 2^E to make a base tick. A 4-bit count L sets how many ticks SCL stays low, and a 4-bit count H sets how many ticks it stays high. While `en_i` is high, the block runs a low phase followed by a high phase, period after period. It marks the start of each phase with a one-cycle strobe and brings out the base tick.

The configuration is captured only at the start of each period, which is the falling edge of SCL. Software can therefore rewrite the word at any time without producing a shortened or stretched phase. A combinational helper turns a requested ratio of system clock to bus rate into a matching configuration word. It halves the ratio until it drops below 16, counts the halvings as E, and rounds up if any discarded bit was set. The word it produces, fed back into `cfg_i`, gives an SCL period of the reduced ratio times 2^E cycles.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst_ni` is low, `scl_o` is 1 and `fall_o`, `rise_o` and `tick_o` are 0. The same holds whenever `en_i` has been low for a cycle.
- R2: While enabled, `tick_o` pulses once every 2^E clock cycles, where E is bits 3:0 of the captured configuration. `scl_o` changes only on the clock edge at which `tick_o` was high.
- R3: Each low phase of `scl_o` lasts (L+1)·2^E cycles, where L is bits 15:12 of the captured configuration.
- R4: Each high phase of `scl_o` between two low phases lasts (H+1)·2^E cycles, where H is bits 19:16 of the captured configuration.
- R5: `fall_o` is high exactly in the first cycle of each low phase, and `rise_o` is high exactly in the first cycle of each high phase.
- R6: `cfg_i` is captured at each falling edge of `scl_o`. A change in the middle of a period does not alter the phase under way or the high phase that follows it.
- R7: When `en_i` goes low, `scl_o` is 1 and both strobes are 0 from the next cycle, and all counters are cleared. After `en_i` rises again, the first falling edge of `scl_o` comes on the 2^E-th enabled clock edge, with E taken from `cfg_i` while the block was disabled.
- R8: The helper derives E as the number of halvings needed to bring `ratio_i` below 16. The reduced ratio is the truncated result, plus 1 if any discarded bit was 1; this equals the ceiling of `ratio_i`/2^E.
- R9: `calc_cfg_o` is 0xFFF00300 OR H<<16 OR L<<12 OR E, with L = reduced/2 − 1 (integer division) and H = reduced − L − 2. Used as `cfg_i`, it gives an SCL period of reduced·2^E cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds SCL high and clears counters |
| cfg_i | input | 32 | Timing word: E at 3:0, L at 15:12, H at 19:16 |
| ratio_i | input | RATIO_W | Requested clock-to-bus-rate ratio for the helper |
| scl_o | output | 1 | SCL phase: 0 low phase, 1 high phase |
| fall_o | output | 1 | One-cycle strobe at the start of a low phase |
| rise_o | output | 1 | One-cycle strobe at the start of a high phase |
| tick_o | output | 1 | Prescaled base tick |
| calc_cfg_o | output | 32 | Configuration word derived from `ratio_i` |

## Verification
The assertions assume that `en_i` is low while reset is applied. They also assume that `ratio_i` is at least 2, because a smaller ratio makes the low count wrap. The stimulus changes `en_i`, `cfg_i` and `ratio_i` only on falling clock edges, holds `en_i` low through reset, and uses ratios from 2 upward. Exponents in the timing runs stay small so that every low and high phase of a period can be measured and checked against the queued expectations within a short run.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  localparam int EXP_W   = 4;
  localparam int CNT_W   = 4;
  localparam int CFG_W   = 32;
  localparam int EXP_LSB = 0;
  localparam int LO_LSB  = 12;
  localparam int HI_LSB  = 16;
  localparam logic [CFG_W-1:0] CFG_FIXED = 32'hFFF0_0300;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
    logic [EXP_W-1:0] ex;
  } scl_fields_t;

  function automatic scl_fields_t cfg_unpack(input logic [CFG_W-1:0] w);
    scl_fields_t f;
    f.ex = w[EXP_LSB +: EXP_W];
    f.lo = w[LO_LSB +: CNT_W];
    f.hi = w[HI_LSB +: CNT_W];
    return f;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input scl_fields_t f);
    return CFG_FIXED
         | (CFG_W'(f.hi) << HI_LSB)
         | (CFG_W'(f.lo) << LO_LSB)
         | (CFG_W'(f.ex) << EXP_LSB);
  endfunction
endpackage

// File: rtl/scl_ratio_conv.sv
module scl_ratio_conv
  import scl_timing_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [CFG_W-1:0]   cfg_o
);
  localparam int LIMIT = 1 << CNT_W;
  localparam int RED_W = CNT_W + 1;

  logic [RATIO_W-1:0] r;
  logic               sticky;
  logic [EXP_W-1:0]   ex;
  logic [RED_W-1:0]   red, half, lo_w, hi_w;
  scl_fields_t        f;

  always_comb begin
    r      = ratio_i;
    sticky = 1'b0;
    ex     = '0;
    // unrolled halving; each stage shifts only while r is still too big
    for (int i = 0; i < RATIO_W; i++) begin
      if (r >= RATIO_W'(LIMIT)) begin
        sticky = sticky | r[0];
        r      = r >> 1;
        ex     = ex + 1'b1;
      end
    end
    red  = RED_W'(r) + RED_W'(sticky);
    half = red >> 1;
    lo_w = half - RED_W'(1);
    hi_w = red - lo_w - RED_W'(2);
    f.ex = ex;
    f.lo = lo_w[CNT_W-1:0];
    f.hi = hi_w[CNT_W-1:0];
    cfg_o = cfg_pack(f);
  end
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int PRE_W = (1 << EXP_W) - 1;

  logic [PRE_W-1:0] pre_q, mask;

  assign mask   = ~({PRE_W{1'b1}} << exp_i);
  assign tick_o = en_i && (pre_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!en_i || tick_o)   pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  AST_PRE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= mask); // R2
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_timing_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [EXP_W-1:0] exp_o,
  output logic             scl_o,
  output logic             fall_o,
  output logic             rise_o
);
  scl_fields_t      cur_q, nxt_f;
  logic [CNT_W-1:0] cnt_q;
  logic             scl_q, fall_q, rise_q;
  logic             lo_end, hi_end;

  assign nxt_f  = cfg_unpack(cfg_i);
  assign lo_end = (cnt_q == cur_q.lo);
  assign hi_end = (cnt_q == cur_q.hi);
  assign exp_o  = cur_q.ex;
  assign scl_o  = scl_q;
  assign fall_o = fall_q;
  assign rise_o = rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      cnt_q  <= '0;
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else if (!en_i) begin
      // park at the end of a high phase so the first tick starts a period
      cur_q  <= nxt_f;
      cnt_q  <= nxt_f.hi;
      scl_q  <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      if (tick_i) begin
        if (!scl_q) begin
          if (lo_end) begin
            scl_q  <= 1'b1;
            cnt_q  <= '0;
            rise_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (hi_end) begin
            scl_q  <= 1'b0;
            cnt_q  <= '0;
            fall_q <= 1'b1;
            cur_q  <= nxt_f;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (scl_o && !fall_o && !rise_o)); // R7
  AST_STEP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(tick_i)) |-> (scl_q == $past(scl_q))); // R2
  AST_FALL_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!scl_o && $past(scl_o))); // R5
  AST_RISE_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (scl_o && !$past(scl_o))); // R5
  AST_LOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_q |-> (cnt_q <= cur_q.lo)); // R3
  AST_HIGH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_q |-> (cnt_q <= cur_q.hi)); // R4
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !fall_q) |-> (cur_q == $past(cur_q))); // R6
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [31:0]        cfg_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               scl_o,
  output logic               fall_o,
  output logic               rise_o,
  output logic               tick_o,
  output logic [31:0]        calc_cfg_o
);
  logic [EXP_W-1:0] cur_exp;
  logic             tick;

  scl_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .exp_i  (cur_exp),
    .tick_o (tick)
  );

  scl_phase_ctl u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick),
    .cfg_i  (cfg_i),
    .exp_o  (cur_exp),
    .scl_o  (scl_o),
    .fall_o (fall_o),
    .rise_o (rise_o)
  );

  scl_ratio_conv #(.RATIO_W(RATIO_W)) u_conv (
    .ratio_i (ratio_i),
    .cfg_o   (calc_cfg_o)
  );

  assign tick_o = tick;
endmodule

// File: tb/sim_scl_timing_gen.sv
`timescale 1ns/1ps
module sim_scl_timing_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [15:0] ratio_i = 16'd2;
  logic        scl_o, fall_o, rise_o, tick_o;
  logic [31:0] calc_cfg_o;

  always #2.5 clk_i = ~clk_i;

  scl_timing_gen #(.RATIO_W(16)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cfg_i(cfg_i),
    .ratio_i(ratio_i), .scl_o(scl_o), .fall_o(fall_o), .rise_o(rise_o),
    .tick_o(tick_o), .calc_cfg_o(calc_cfg_o)
  );

  typedef struct { bit low; int cyc; string tag; } exp_t;
  exp_t sb_q[$];
  int total = 0, bad = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(int e, int lo, int hi);
    return 32'hFFF0_0300 | 32'(hi << 16) | 32'(lo << 12) | 32'(e);
  endfunction

  // ceiling formulation of the halving-with-sticky rule
  function automatic logic [31:0] model_cfg(int r);
    int e = 0, red, lo, hi;
    while ((r >> e) >= 16) e++;
    red = (r + (1 << e) - 1) >> e;
    lo  = red / 2 - 1;
    hi  = red - lo - 2;
    return mk(e, lo, hi);
  endfunction

  task automatic push_cfg(int e, int lo, int hi, int n);
    for (int i = 0; i < n; i++) begin
      sb_q.push_back('{1'b1, (lo + 1) << e, "R3"});
      sb_q.push_back('{1'b0, (hi + 1) << e, "R4"});
    end
  endtask

  task automatic drain_and_stop();
    wait (sb_q.size() == 0);
    en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: measures phases and compares against the queue
  int mcnt = 0;
  bit meas = 0, in_high = 0, prev_scl = 1;

  task automatic sb_pop(bit low, int cyc);
    exp_t it;
    if (sb_q.size() == 0) return;
    it = sb_q.pop_front();
    check(it.low == low && it.cyc == cyc, it.tag,
          low ? "low phase cycles" : "high phase cycles", cyc, it.cyc);
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni || !en_i) begin
      meas = 0; in_high = 0; mcnt = 0;
    end else if (fall_o) begin
      check(!scl_o && prev_scl, "R5", "fall strobe vs scl", scl_o, 0);
      if (meas && in_high) sb_pop(1'b0, mcnt);
      meas = 1; in_high = 0; mcnt = 1;
    end else if (rise_o) begin
      check(scl_o && !prev_scl, "R5", "rise strobe vs scl", scl_o, 1);
      if (meas && !in_high) sb_pop(1'b1, mcnt);
      in_high = 1; mcnt = 1;
    end else begin
      mcnt++;
    end
    prev_scl = scl_o;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n;
    int rl[9] = '{2, 3, 15, 16, 17, 31, 100, 1000, 40000};
    repeat (3) @(negedge clk_i);
    check(scl_o == 1'b1, "R1", "scl in reset", scl_o, 1);
    check(fall_o == 1'b0, "R1", "fall in reset", fall_o, 0);
    check(rise_o == 1'b0, "R1", "rise in reset", rise_o, 0);
    check(tick_o == 1'b0, "R1", "tick in reset", tick_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(scl_o == 1'b1 && tick_o == 1'b0, "R1", "idle after reset", scl_o, 1);

    // helper conversions, R8 and R9
    foreach (rl[i]) begin
      ratio_i = 16'(rl[i]);
      #1;
      check(calc_cfg_o == model_cfg(rl[i]), "R8", "converted word", calc_cfg_o, model_cfg(rl[i]));
    end
    ratio_i = 16'd17;   #1;
    check(calc_cfg_o == mk(1, 3, 4), "R8", "ratio 17 sticky", calc_cfg_o, mk(1, 3, 4));
    ratio_i = 16'd1000; #1;
    check(calc_cfg_o == mk(6, 7, 7), "R9", "ratio 1000 word", calc_cfg_o, mk(6, 7, 7));
    ratio_i = 16'd16;   #1;
    check(calc_cfg_o == mk(1, 3, 3), "R9", "ratio 16 word", calc_cfg_o, mk(1, 3, 3));
    @(negedge clk_i);

    // R3 R4: undivided, asymmetric phases
    cfg_i = mk(0, 2, 5);
    push_cfg(0, 2, 5, 3);
    en_i = 1'b1;
    drain_and_stop();

    // R3 R4: minimum counts with prescale
    cfg_i = mk(2, 0, 0);
    push_cfg(2, 0, 0, 2);
    en_i = 1'b1;
    drain_and_stop();

    // R9 end to end: helper output drives the timing word
    ratio_i = 16'd100;
    #1;
    cfg_i = calc_cfg_o;
    push_cfg(3, 5, 6, 2);
    @(negedge clk_i);
    en_i = 1'b1;
    drain_and_stop();

    // R2 tick spacing
    cfg_i = mk(3, 1, 1);
    @(negedge clk_i);
    en_i = 1'b1;
    do @(negedge clk_i); while (!tick_o);
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk_i); n++; end while (!tick_o);
      check(n == 8, "R2", "cycles between ticks", n, 8);
    end
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);

    // R6: rewrite during the high phase, old timing must finish the period
    cfg_i = mk(0, 3, 4);
    sb_q.push_back('{1'b1, 4, "R6"});
    sb_q.push_back('{1'b0, 5, "R6"});
    sb_q.push_back('{1'b1, 6, "R6"});
    sb_q.push_back('{1'b0, 6, "R6"});
    en_i = 1'b1;
    wait (sb_q.size() == 3);
    cfg_i = mk(1, 2, 2);
    drain_and_stop();

    // R7: disable mid-phase, then re-enable latency
    cfg_i = mk(1, 4, 4);
    en_i = 1'b1;
    repeat (7) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check(scl_o == 1'b1, "R7", "scl after disable", scl_o, 1);
    check(!fall_o && !rise_o, "R7", "strobes after disable", fall_o | rise_o, 0);
    check(tick_o == 1'b0, "R7", "tick after disable", tick_o, 0);
    cfg_i = mk(2, 1, 1);
    @(negedge clk_i);
    en_i = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (scl_o && n < 100);
    check(n == 4, "R7", "edges to first fall", n, 4);
    check(fall_o == 1'b1, "R5", "fall strobe at first fall", fall_o, 1);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);

    summary();
    $finish;
  end
endmodule